// File: doc/BRIEF.md
# Configurable Single-Port Synchronous RAM

This block is an on-chip word memory reached through one port. A single address selects the word that is read and, in the same cycle, the word that is written. Elaboration parameters set the word width and the depth. They also select whether the port can write at all, and whether reads are combinational or registered. A registered read can get an optional enable. Writes can be split into independently enabled slices. A parameter selects what the read output shows during a cycle that writes.

The memory can be preloaded at configuration time from a packed parameter image. Only the first `INIT_LEN` words are taken from the image, and every other word starts at zero. The storage is written so that block RAM can be inferred. Only the read output register sees the synchronous reset. Memory contents are never cleared by reset.

Top module: `spram_port`

## Requirements
- R1: With registered reads, a high `rst` at a clock edge clears `rd_data` to zero.
- R2: A write with every slice enabled stores `wr_data` at `addr`. A later registered read of that address returns the word one clock after the address is presented.
- R3: `wr_en` has one bit per slice, where a slice is `SLICE_W` bits wide. Bit k writes bits `[k*SLICE_W +: SLICE_W]`, and slices whose bit is low keep their contents.
- R4: With `RDW_MODE` = new-data (encoding 1, the default), a read in a write cycle returns the written value in enabled slices and the previous contents in the other slices.
- R5: With `RDW_MODE` = old-data (encoding 0), a read in a write cycle returns the word's previous contents.
- R6: With `RDW_MODE` = hold (encoding 2), `rd_data` keeps its value in every cycle in which any `wr_en` bit is high. Plain reads update it.
- R7: With `HAS_RD_EN` = 1 and registered reads, `rd_data` keeps its value while `rd_en` is low. Writes in those cycles still reach the memory.
- R8: With `READ_ASYNC` = 1, `rd_data` shows the current contents at `addr` combinationally. `rd_en` and `RDW_MODE` have no effect.
- R9: After configuration, word i holds `INIT_IMG[i*DATA_W +: DATA_W]` for i < `INIT_LEN`, and zero otherwise.
- R10: With `WRITABLE` = 0, `wr_en` is ignored and the contents stay at their preload values.
- R11: With `SLICE_W` = 0, `wr_en` is one bit wide and writes the whole word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the read register |
| addr | input | ADDR_W | Word address, ADDR_W = ceil(log2(DEPTH)) |
| rd_en | input | 1 | Read enable for registered reads (used when HAS_RD_EN = 1) |
| wr_en | input | LANES | Per-slice write enables, LANES = DATA_W / SLICE_W (1 when SLICE_W = 0) |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data |

## Verification
The hardest case is a partial write: one slice is enabled while the word already holds known, distinct data in every slice. Only then does the new-data policy show its per-slice mix of fresh and old bits. The bench first fills every address with full-word patterns. It then sweeps single-slice writes with inverted data across all addresses, so each enabled slice and each untouched slice differ visibly. Six instances receive the same stimulus: new-data, old-data, hold, combinational read, read-only, and whole-word write. Their outputs are compared against per-policy models kept in the bench.

// File: rtl/spram_pkg.sv
package spram_pkg;

  typedef enum logic [1:0] {
    RDW_OLD  = 2'd0,
    RDW_NEW  = 2'd1,
    RDW_HOLD = 2'd2
  } rdw_mode_e;

  function automatic int lane_width(input int data_w, input int slice_w);
    return (slice_w == 0) ? data_w : slice_w;
  endfunction

  function automatic int lane_count(input int data_w, input int slice_w);
    return data_w / lane_width(data_w, slice_w);
  endfunction

endpackage

// File: rtl/spram_array.sv
module spram_array #(
  parameter int DATA_W   = 16,
  parameter int DEPTH    = 32,
  parameter int LANES    = 2,
  parameter int ADDR_W   = 5,
  parameter int INIT_LEN = 0,
  parameter logic [DEPTH*DATA_W-1:0] INIT_IMG = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] word_o
);

  localparam int LANE_W = DATA_W / LANES;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              in_range;

  assign in_range = (int'(addr) < DEPTH);

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = (i < INIT_LEN) ? INIT_IMG[i*DATA_W +: DATA_W] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (in_range) begin
      for (int s = 0; s < LANES; s++) begin
        if (lane_we[s]) begin
          mem[addr][s*LANE_W +: LANE_W] <= wdata[s*LANE_W +: LANE_W];
        end
      end
    end
  end

  assign word_o = in_range ? mem[addr] : '0;

  // R2: a full-word write is visible at the same address one cycle later
  a_r2_full_write : assert property (@(posedge clk) disable iff (rst)
    (&lane_we) |=> ((addr != $past(addr)) || (word_o == $past(wdata))));

  // R3: the lowest slice is untouched while its enable is low
  a_r3_lane_keep : assert property (@(posedge clk) disable iff (rst)
    (!lane_we[0]) |=> ((addr != $past(addr)) ||
                       (word_o[LANE_W-1:0] == $past(word_o[LANE_W-1:0]))));

endmodule

// File: rtl/spram_merge.sv
module spram_merge #(
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  lane_we,
  output logic [DATA_W-1:0] merged,
  output logic              any_we
);

  localparam int LANE_W = DATA_W / LANES;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*LANE_W +: LANE_W] = lane_we[g] ? wdata[g*LANE_W +: LANE_W]
                                                   : old_word[g*LANE_W +: LANE_W];
  end

  assign any_we = |lane_we;

endmodule

// File: rtl/spram_rd_stage.sv
module spram_rd_stage
  import spram_pkg::*;
#(
  parameter int        DATA_W     = 16,
  parameter bit        READ_ASYNC = 1'b0,
  parameter bit        HAS_RD_EN  = 1'b1,
  parameter rdw_mode_e RDW_MODE   = RDW_NEW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              any_we,
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] merged,
  output logic [DATA_W-1:0] rd_data
);

  if (READ_ASYNC) begin : g_async
    logic unused_async;
    assign unused_async = ^{clk, rst, rd_en, any_we, merged};
    assign rd_data = old_word;
  end else begin : g_sync
    logic              rd_go;
    logic [DATA_W-1:0] rd_q;
    logic              unused_en;

    assign unused_en = rd_en;
    assign rd_go     = HAS_RD_EN ? rd_en : 1'b1;

    always_ff @(posedge clk) begin
      if (rst) begin
        rd_q <= '0;
      end else if (rd_go) begin
        case (RDW_MODE)
          RDW_OLD:  rd_q <= old_word;
          RDW_HOLD: if (!any_we) rd_q <= old_word;
          default:  rd_q <= merged;
        endcase
      end
    end

    assign rd_data = rd_q;

    if (HAS_RD_EN) begin : g_en_chk
      // R7: disabled read keeps the output
      a_r7_enable_hold : assert property (@(posedge clk) disable iff (rst)
        (!rd_en) |=> $stable(rd_q));
    end

    if (RDW_MODE == RDW_OLD) begin : g_old_chk
      // R5: output shows contents from before the edge
      a_r5_old_data : assert property (@(posedge clk) disable iff (rst)
        rd_go |=> (rd_q == $past(old_word)));
    end else if (RDW_MODE == RDW_HOLD) begin : g_hold_chk
      // R6: a write cycle leaves the output alone
      a_r6_hold_on_write : assert property (@(posedge clk) disable iff (rst)
        (rd_go && any_we) |=> $stable(rd_q));
    end else begin : g_new_chk
      // R4: with no write, the output is the stored word
      a_r4_plain_read : assert property (@(posedge clk) disable iff (rst)
        (rd_go && !any_we) |=> (rd_q == $past(old_word)));
    end
  end

endmodule

// File: rtl/spram_port.sv
module spram_port
  import spram_pkg::*;
#(
  parameter int        DATA_W     = 16,
  parameter int        DEPTH      = 32,
  parameter int        SLICE_W    = 8,
  parameter bit        WRITABLE   = 1'b1,
  parameter bit        READ_ASYNC = 1'b0,
  parameter bit        HAS_RD_EN  = 1'b1,
  parameter rdw_mode_e RDW_MODE   = RDW_NEW,
  parameter int        INIT_LEN   = 0,
  parameter logic [DEPTH*DATA_W-1:0] INIT_IMG = '0,
  localparam int       ADDR_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int       LANES      = lane_count(DATA_W, SLICE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic [LANES-1:0]  wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  initial begin
    a_cfg_slice : assert (SLICE_W == 0 || (DATA_W % SLICE_W) == 0)
      else $error("DATA_W must be a multiple of SLICE_W");
  end

  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] old_word;
  logic [DATA_W-1:0] merged;
  logic              any_we;

  if (WRITABLE) begin : g_wr
    assign lane_we = wr_en;
  end else begin : g_ro
    logic unused_ro;
    assign unused_ro = ^{wr_en, wr_data};
    assign lane_we   = '0;
  end

  spram_array #(
    .DATA_W   (DATA_W),
    .DEPTH    (DEPTH),
    .LANES    (LANES),
    .ADDR_W   (ADDR_W),
    .INIT_LEN (INIT_LEN),
    .INIT_IMG (INIT_IMG)
  ) u_array (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .lane_we (lane_we),
    .wdata   (wr_data),
    .word_o  (old_word)
  );

  spram_merge #(
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) u_merge (
    .old_word (old_word),
    .wdata    (wr_data),
    .lane_we  (lane_we),
    .merged   (merged),
    .any_we   (any_we)
  );

  spram_rd_stage #(
    .DATA_W     (DATA_W),
    .READ_ASYNC (READ_ASYNC),
    .HAS_RD_EN  (HAS_RD_EN),
    .RDW_MODE   (RDW_MODE)
  ) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .any_we   (any_we),
    .old_word (old_word),
    .merged   (merged),
    .rd_data  (rd_data)
  );

endmodule

// File: tb/test_spram_port.sv
module test_spram_port;
  import spram_pkg::*;

  localparam int PER   = 10;
  localparam int DW    = 16;
  localparam int DEPTH = 16;
  localparam int AW    = 4;
  localparam int NINIT = 4;

  function automatic logic [DW-1:0] init_word(input int i);
    return (i < NINIT) ? (16'hC0DE ^ (16'(i) * 16'h0101)) : 16'h0000;
  endfunction

  function automatic logic [DEPTH*DW-1:0] make_img();
    logic [DEPTH*DW-1:0] img;
    img = '0;
    for (int i = 0; i < NINIT; i++) img[i*DW +: DW] = init_word(i);
    for (int i = NINIT; i < DEPTH; i++) img[i*DW +: DW] = 16'hFFFF; // beyond INIT_LEN: must be ignored
    return img;
  endfunction

  localparam logic [DEPTH*DW-1:0] IMG = make_img();

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          rd_en = 1'b0;
  logic [1:0]    wr_en = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] o_wf, o_rf, o_nc, o_as, o_ro, o_s0;
  logic [0:0]    we_full;

  assign we_full = &wr_en;

  always #(PER/2) clk = ~clk;

  spram_port #(.DATA_W(DW), .DEPTH(DEPTH), .SLICE_W(8), .RDW_MODE(RDW_NEW),
               .INIT_LEN(NINIT), .INIT_IMG(IMG)) i_spram_port (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(o_wf));

  spram_port #(.DATA_W(DW), .DEPTH(DEPTH), .SLICE_W(8), .RDW_MODE(RDW_OLD),
               .INIT_LEN(NINIT), .INIT_IMG(IMG)) i_spram_port_rf (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(o_rf));

  spram_port #(.DATA_W(DW), .DEPTH(DEPTH), .SLICE_W(8), .RDW_MODE(RDW_HOLD),
               .INIT_LEN(NINIT), .INIT_IMG(IMG)) i_spram_port_nc (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(o_nc));

  spram_port #(.DATA_W(DW), .DEPTH(DEPTH), .SLICE_W(8), .READ_ASYNC(1'b1),
               .RDW_MODE(RDW_OLD), .INIT_LEN(NINIT), .INIT_IMG(IMG)) i_spram_port_as (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(o_as));

  spram_port #(.DATA_W(DW), .DEPTH(DEPTH), .SLICE_W(8), .WRITABLE(1'b0),
               .INIT_LEN(NINIT), .INIT_IMG(IMG)) i_spram_port_ro (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(o_ro));

  spram_port #(.DATA_W(DW), .DEPTH(DEPTH), .SLICE_W(0),
               .INIT_LEN(NINIT), .INIT_IMG(IMG)) i_spram_port_s0 (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(we_full),
    .wr_data(wr_data), .rd_data(o_s0));

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [DW-1:0] mdl  [DEPTH];
  logic [DW-1:0] mdl5 [DEPTH];
  logic [DW-1:0] e_wf, e_rf, e_nc, e_ro, e_s0;

  task automatic chk(input string req, input string who,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, who, act, exp);
    end
  endtask

  function automatic string pick(input string ph, input string own);
    return (ph == "") ? own : ph;
  endfunction

  task automatic step(input logic [AW-1:0] a, input logic [1:0] we,
                      input logic [DW-1:0] wd, input logic re, input string ph);
    logic [DW-1:0] old, mix;
    @(negedge clk);
    addr = a; wr_en = we; wr_data = wd; rd_en = re;
    old = mdl[a];
    mix[7:0]  = we[0] ? wd[7:0]  : old[7:0];
    mix[15:8] = we[1] ? wd[15:8] : old[15:8];
    if (re) begin
      e_wf = mix;
      e_rf = old;
      if (we == 2'b00) e_nc = old;
      e_ro = init_word(int'(a));
      e_s0 = (&we) ? wd : mdl5[a];
    end
    mdl[a] = mix;
    if (&we) mdl5[a] = wd;
    @(posedge clk);
    #(PER/4);
    chk(pick(ph, "R4"),  "new-data",   o_wf, e_wf);
    chk(pick(ph, "R5"),  "old-data",   o_rf, e_rf);
    chk(pick(ph, "R6"),  "hold",       o_nc, e_nc);
    chk(pick(ph, "R8"),  "comb-read",  o_as, mdl[a]);
    chk(pick(ph, "R10"), "read-only",  o_ro, e_ro);
    chk(pick(ph, "R11"), "whole-word", o_s0, e_s0);
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return 16'h5A00 + 16'(a) * 16'h0103;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mdl[i]  = init_word(i);
      mdl5[i] = init_word(i);
    end
    e_wf = '0; e_rf = '0; e_nc = '0; e_ro = '0; e_s0 = '0;

    // R1: reset clears every registered output
    repeat (3) @(posedge clk);
    #(PER/4);
    chk("R1", "new-data",   o_wf, 16'h0);
    chk("R1", "old-data",   o_rf, 16'h0);
    chk("R1", "hold",       o_nc, 16'h0);
    chk("R1", "read-only",  o_ro, 16'h0);
    chk("R1", "whole-word", o_s0, 16'h0);
    @(negedge clk);
    rst = 1'b0;

    // R9: preload contents, zero beyond INIT_LEN
    for (int a = 0; a < DEPTH; a++) step(AW'(a), 2'b00, 16'h0, 1'b1, "R9");

    // R2 / R4 / R5 / R6 / R8 / R10 / R11: full-word writes
    for (int a = 0; a < DEPTH; a++) step(AW'(a), 2'b11, pat(a), 1'b1, "");
    for (int a = 0; a < DEPTH; a++) step(AW'(a), 2'b00, 16'h0, 1'b1, "R2");

    // R3: single-slice writes with inverted data, then read back
    for (int a = 0; a < DEPTH; a++)
      step(AW'(a), (a % 2 == 0) ? 2'b01 : 2'b10, ~pat(a), 1'b1, "");
    for (int a = 0; a < DEPTH; a++) step(AW'(a), 2'b00, 16'h0, 1'b1, "R3");

    // R7: read enable low holds output while writes land
    for (int a = 0; a < 8; a++) step(AW'(a), 2'b11, 16'h3C00 ^ 16'(a * 77), 1'b0, "R7");
    for (int a = 0; a < 8; a++) step(AW'(a), 2'b00, 16'h0, 1'b0, "R7");
    for (int a = 0; a < 8; a++) step(AW'(a), 2'b00, 16'h0, 1'b1, "R7");

    // back-to-back writes to one address in all policies
    for (int k = 0; k < 4; k++) step(AW'(5), 2'(k), 16'hA5A5 + 16'(k), 1'b1, "");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(PER * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule